// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

An eight-stage register that either takes a whole parallel word or shifts one serial bit in per register event. Only the last stage is driven out. The register has no clock of its own in the data sense. Two request lines, `req_a_i` and `req_b_i`, are ORed, and a register event fires when that OR goes from low to high. Because of the OR, either line can serve as the clock while the other, held high, blocks it as an active-high inhibit. An active-low parallel-enable selects a load rather than a shift at each event.

The design is fully synchronous to a free-running system clock `clk_i`. Each request line passes through its own two-flop synchronizer. The OR of the synchronized lines is registered, and the event is the registered OR seen high after being low. The reset `rst_ni` clears the stages asynchronously and overrides every other input. The edge logic comes out of reset synchronously, and it stays blanked for one cycle after release, so a request line that is already high at that moment is not taken as an edge. The data inputs and the parallel-enable are sampled on the system-clock edge at which the event is applied. They must therefore be stable across the request pulse.

Top module: `gsr_shift_reg`

## Requirements
- R1: While `rst_ni` is low, all eight stages are zero and `last_o` is 0, without waiting for a `clk_i` edge. This overrides every other input.
- R2: A register event occurs only when one request line rises while the other request line is low.
- R3: While either request line is held high, no event occurs. This holds no matter how often the other line pulses.
- R4: At an event with `load_ni` = 0, stage k takes `par_i[k]` for k = 0..7. `last_o` then equals `par_i[7]`.
- R5: At an event with `load_ni` = 1, stage 0 takes `ser_i` and stage k takes the old stage k-1 for k = 1..7. `last_o` then equals the old stage 6.
- R6: Without an event, the stages keep their contents whatever `load_ni`, `par_i` and `ser_i` do.
- R7: A request line that is already high when reset is released produces no event.
- R8: The request input is driven between clock edges. The event takes effect at the fourth rising `clk_i` edge after it is driven, and `last_o` shows the result from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low master reset: asynchronous clear, synchronous release of the edge logic |
| req_a_i | input | 1 | Clock request A; acts as the clock or, held high, as an inhibit |
| req_b_i | input | 1 | Clock request B; same role as A |
| load_ni | input | 1 | Active-low parallel-enable: 0 loads, 1 shifts |
| ser_i | input | 1 | Serial data shifted into stage 0 |
| par_i | input | 8 | Parallel word; bit k goes to stage k |
| last_o | output | 1 | Content of the last stage (stage 7) |

## Verification
Only stage 7 is visible. A wrong value in stage k therefore reaches `last_o` only after 7-k further shifts, and a single check after an event can miss it. For this reason the bench keeps a full eight-stage model and compares `last_o` after every event. After the inhibit, reset and hold scenarios it runs complete eight-shift drains, so that every stage is brought out. A spurious or missing event shows up as a pattern that is offset by one position. This appears at the port within a few events of the fault.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } gsr_op_e;

  function automatic gsr_op_e gsr_pick_op(input logic fire, input logic load_n);
    if (!fire)  return OP_HOLD;
    if (!load_n) return OP_LOAD;
    return OP_SHIFT;
  endfunction
endpackage

// File: rtl/gsr_req_sync.sv
module gsr_req_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    // reset to 1: a line already high at release is not an edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], req_i[g]};
    end
    assign req_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gsr_edge.sv
module gsr_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic         fire_o
);
  logic or_q, prev_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      or_q   <= 1'b1;
      prev_q <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      or_q   <= |req_i;
      prev_q <= or_q;
      arm_q  <= 1'b1;
    end
  end

  assign fire_o = arm_q & or_q & ~prev_q;

  // R2: an event needs a request line that was seen high
  assert_event_from_request_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(|req_i));
  // R3: a line held high two cycles back forbids an event
  assert_no_event_when_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ##1 !fire_o);
endmodule

// File: rtl/gsr_stages.sv
module gsr_stages
  import gsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             load_ni,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  gsr_op_e          op;
  logic [WIDTH-1:0] q_q, q_d;

  assign op = gsr_pick_op(fire_i, load_ni);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic shift_in;
    if (b == 0) begin : g_head
      assign shift_in = ser_i;
    end else begin : g_body
      assign shift_in = q_q[b-1];
    end
    always_comb begin
      unique case (op)
        OP_LOAD:  q_d[b] = par_i[b];
        OP_SHIFT: q_d[b] = shift_in;
        default:  q_d[b] = q_q[b];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R1: stages are clear while reset is held
  always @(negedge clk_i) begin
    if (!rst_ni) assert_clear_in_reset_R1: assert (q_q == '0);
  end
  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !load_ni) |=> (q_q == $past(par_i)));
  assert_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && load_ni) |=> (q_q == {$past(q_q[WIDTH-2:0]), $past(ser_i)}));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(q_q));
endmodule

// File: rtl/gsr_shift_reg.sv
module gsr_shift_reg #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_a_i,
  input  logic             req_b_i,
  input  logic             load_ni,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             last_o
);
  localparam int unsigned NREQ = 2;

  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic [NREQ-1:0] req_s;
  logic            fire;
  logic [WIDTH-1:0] stage_q;

  // async assert, sync release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  gsr_req_sync #(.N(NREQ), .STAGES(SYNC_STGS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .req_i  ({req_b_i, req_a_i}),
    .req_o  (req_s)
  );

  gsr_edge #(.N(NREQ)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .req_i  (req_s),
    .fire_o (fire)
  );

  gsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .load_ni (load_ni),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .q_o     (stage_q)
  );

  assign last_o = stage_q[WIDTH-1];

  // R7: no event in the first cycle after edge logic leaves reset
  assert_release_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_sync_n) |-> !fire);
endmodule

// File: tb/gsr_shift_reg_bench.sv
module gsr_shift_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       req_a = 1'b0, req_b = 1'b0;
  logic       load_n = 1'b1, ser = 1'b0;
  logic [7:0] par = 8'h00;
  logic       last;
  logic [7:0] model = 8'h00;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  gsr_shift_reg u_gsr_shift_reg (
    .clk_i(clk), .rst_ni(rst_n), .req_a_i(req_a), .req_b_i(req_b),
    .load_ni(load_n), .ser_i(ser), .par_i(par), .last_o(last)
  );

  function automatic logic [7:0] next_state(input logic [7:0] q, input logic ld_n,
                                            input logic [7:0] p, input logic s);
    return ld_n ? {q[6:0], s} : p;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s last_o=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one pulse on a request line; data held stable across it
  task automatic pulse(input bit chan, input string req);
    bit fires;
    fires = !req_a && !req_b;
    @(negedge clk);
    if (chan) req_b = 1'b1; else req_a = 1'b1;
    repeat (6) @(negedge clk);
    if (fires) model = next_state(model, load_n, par, ser);
    check(req, last, model[7]);
    if (chan) req_b = 1'b0; else req_a = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // eight shifts bring every stage to last_o
  task automatic drain(input string req);
    load_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser = 1'($urandom);
      pulse(i[0], req);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3a5e77));
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", last, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 load then R5 eight shifts of a known pattern
    load_n = 1'b0; par = 8'hA5;
    pulse(1'b0, "R4 load A5");
    load_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser = 1'(i % 3 == 0);
      pulse(i[0], "R5 shift pattern");
    end

    // R8 latency: event lands on the 4th clk edge after the drive
    load_n = 1'b0; par = 8'h00;
    pulse(1'b0, "R4 load 00");
    par = 8'h80;
    @(negedge clk); req_a = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R8 not before 4th edge", last, 1'b0);
    @(posedge clk);
    #1 check("R8 at 4th edge", last, 1'b1);
    model = 8'h80;
    @(negedge clk); req_a = 1'b0;
    repeat (6) @(negedge clk);

    // R3 inhibit: B high, A pulses have no effect
    load_n = 1'b0; par = 8'h3C;
    pulse(1'b1, "R4 load 3C");
    @(negedge clk); req_b = 1'b1;
    repeat (6) @(negedge clk);
    load_n = 1'b0; par = 8'hFF;
    for (int i = 0; i < 3; i++) pulse(1'b0, "R3 inhibited pulse");
    // A rises, B stays high until A is high, then A drops and pulses again
    @(negedge clk); req_a = 1'b1;
    repeat (4) @(negedge clk); req_b = 1'b0;
    repeat (4) @(negedge clk); req_b = 1'b1;
    repeat (4) @(negedge clk); req_a = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 handover no edge", last, model[7]);
    pulse(1'b0, "R3 inhibited again");
    @(negedge clk); req_b = 1'b0;
    repeat (6) @(negedge clk);
    drain("R3 contents kept");

    // R2 and R4/R5 random mix, with R6 data wiggling between events
    for (int n = 0; n < 48; n++) begin
      load_n = ($urandom % 4) != 0;
      par = 8'($urandom);
      ser = 1'($urandom);
      pulse(1'($urandom), load_n ? "R2 R5 random shift" : "R2 R4 random load");
      if (n % 4 == 3) begin
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          load_n = 1'($urandom); par = 8'($urandom); ser = 1'($urandom);
        end
        repeat (3) @(negedge clk);
        check("R6 idle inputs ignored", last, model[7]);
      end
    end
    drain("R6 contents after random");

    // R1 reset in the middle of a shift, R7 line high across release
    load_n = 1'b0; par = 8'hFF;
    pulse(1'b0, "R4 load FF");
    load_n = 1'b1; ser = 1'b1;
    pulse(1'b1, "R5 shift before reset");
    load_n = 1'b0; par = 8'hFF;
    @(negedge clk); req_a = 1'b1;
    @(posedge clk); #1 rst_n = 1'b0;
    #0.5 check("R1 async clear", last, 1'b0);
    model = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 high line at release", last, 1'b0);
    req_a = 1'b0;
    repeat (6) @(negedge clk);
    load_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser = 1'b0;
      pulse(i[0], "R1 R7 all stages clear");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule